// File: doc/BRIEF.md
# Four-Lane Byte-Parallel Self-Test Engine

This block is a self-test engine for a four-lane byte-oriented serial link. The pattern generator can replace ordinary traffic on one of two transmit paths. A separate checker watches one of two receive paths and compares the incoming bytes against a reference that it produces itself. Generation and checking take their pattern and path from independent controls, so the two ends of a link can test different patterns in each direction.

Each lane carries one byte per clock. There are two patterns: a PRBS23 stream (polynomial x^23 + x^18 + 1) and a constant byte that repeats. A lane's checker stays idle until the upstream comma or idle-gap logic reports that lane as byte-aligned. In PRBS mode the checker then loads its reference from the first received bits and runs free after that. Every wrong bit adds to that lane's saturating error counter and sets that lane's sticky error flag. The flags appear directly on output pins. Flags and counters can also be read through a small read port, and reading clears them.

Top module: `bist_engine`

## Requirements
- R1: The generator runs while `gen_en_reg` or `gen_en_pin` is high. While both are low, `tx_a` and `tx_b` show the `norm_tx_a` and `norm_tx_b` values of the previous cycle. Reset drives both transmit outputs to zero.
- R2: While the generator runs, `gen_dir`=0 puts the pattern on `tx_a` and `gen_dir`=1 puts it on `tx_b`, one cycle later. The other path keeps passing its normal traffic with one cycle of delay.
- R3: With `gen_pat`=0, lane i sends PRBS23 from x^23+x^18+1. The lane starts from state 23'h7FFFFF minus i, and that state is reloaded whenever the generator is off. Each clock the lane shifts 8 steps: the new bit is state[22] xor state[17], it enters at state[0], and the first new bit becomes byte bit 7. With `gen_pat`=1 every lane sends the byte FIX_BYTE (default 8'h96).
- R4: `chk_src`=0 checks `rx_a` using `rx_a_aligned`, and `chk_src`=1 checks `rx_b` using `rx_b_aligned`. `chk_pat` uses the same encoding as `gen_pat` and is independent of the generator settings.
- R5: While checking is enabled, a lane counts no errors until its alignment input has been seen high. The lane remembers that alignment until checking is disabled.
- R6: In PRBS mode, the byte received in the aligned cycle and the next two bytes load the lane's reference and are not checked. Every later byte is compared against the next 8 steps of the reference.
- R7: In constant-byte mode, the byte received in the aligned cycle is the first byte checked.
- R8: A checked byte adds the popcount of (received xor expected) to that lane's counter. If that popcount is nonzero, `err_flag[i]` is set. Counter and flag change at the clock edge that samples the byte, and the flag stays set.
- R9: The 16-bit counters saturate at 16'hFFFF.
- R10: When `rd_en` is high, `rd_data` is updated on the next cycle. With `rd_sel`=0 it returns the four flags in bits 3:0 and clears them. With `rd_sel`=1 it returns the counter of lane `rd_lane` and clears that counter. Errors that arrive in the same cycle as the read are kept.
- R11: Driving `chk_en` low clears every flag and resets alignment and the reference on all lanes. The counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en_reg | input | 1 | Generator enable, register bit |
| gen_en_pin | input | 1 | Generator enable, pin |
| gen_dir | input | 1 | Transmit path for pattern (0 A, 1 B) |
| gen_pat | input | 1 | Generated pattern (0 PRBS23, 1 constant) |
| norm_tx_a | input | 32 | Normal traffic, path A |
| norm_tx_b | input | 32 | Normal traffic, path B |
| tx_a | output | 32 | Transmit path A, byte i in bits 8i+7:8i |
| tx_b | output | 32 | Transmit path B |
| chk_en | input | 1 | Checker enable |
| chk_src | input | 1 | Receive path checked (0 A, 1 B) |
| chk_pat | input | 1 | Checked pattern (0 PRBS23, 1 constant) |
| rx_a | input | 32 | Decoded receive bytes, path A |
| rx_b | input | 32 | Decoded receive bytes, path B |
| rx_a_aligned | input | 4 | Per-lane alignment, path A |
| rx_b_aligned | input | 4 | Per-lane alignment, path B |
| err_flag | output | 4 | Sticky per-lane error flags |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 flags, 1 counter |
| rd_lane | input | 2 | Lane whose counter is read |
| rd_data | output | 16 | Read result |

## Verification
The transmit outputs follow their inputs after one cycle. Flags and counters absorb a received byte at the edge that samples it, so the effect shows on `err_flag` immediately after that edge. A counter or flag value shows on `rd_data` one cycle after `rd_en`. In PRBS mode, the first byte that can be wrong is the fourth one after alignment. The bench holds each stimulus across a rising edge and advances its reference model by exactly one edge. It compares the transmit outputs, the flags and any pending read result just after that same edge.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int BYTE_W = 8;
    localparam int PRBS_W = 23;
    localparam int TAP_HI = PRBS_W - 1;
    localparam int TAP_LO = 17;
    localparam int POP_W  = $clog2(BYTE_W + 1);

    typedef enum logic {
        PAT_PRBS  = 1'b0,
        PAT_FIXED = 1'b1
    } pat_e;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_SEED = 2'd1,
        CK_RUN  = 2'd2
    } ck_state_e;

    typedef struct packed {
        logic [PRBS_W-1:0] state;
        logic [BYTE_W-1:0] data;
    } prbs_step_t;

    // Advance the sequence by one byte; earliest bit lands in the MSB.
    function automatic prbs_step_t prbs_advance(input logic [PRBS_W-1:0] s_in);
        prbs_step_t        r;
        logic [PRBS_W-1:0] s;
        logic              nb;
        r = '0;
        s = s_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            nb        = s[TAP_HI] ^ s[TAP_LO];
            s         = {s[PRBS_W-2:0], nb};
            r.data[i] = nb;
        end
        r.state = s;
        return r;
    endfunction

    function automatic logic [POP_W-1:0] ones_in_byte(input logic [BYTE_W-1:0] v);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            n = n + POP_W'(v[i]);
        end
        return n;
    endfunction

    function automatic logic [PRBS_W-1:0] lane_seed(input int lane);
        return {PRBS_W{1'b1}} - PRBS_W'(lane);
    endfunction

endpackage

// File: rtl/bist_gen.sv
module bist_gen
    import bist_pkg::*;
#(
    parameter int                LANES    = 4,
    parameter logic [BYTE_W-1:0] FIX_BYTE = 8'h96
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_reg,
    input  logic                    en_pin,
    input  logic                    dir,
    input  pat_e                    pat,
    input  logic [LANES*BYTE_W-1:0] norm_a,
    input  logic [LANES*BYTE_W-1:0] norm_b,
    output logic [LANES*BYTE_W-1:0] tx_a,
    output logic [LANES*BYTE_W-1:0] tx_b
);
    localparam int BUS_W = LANES * BYTE_W;

    logic             gen_on;
    logic [BUS_W-1:0] gen_bus;

    assign gen_on = en_reg | en_pin;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PRBS_W-1:0] lfsr_q;
        prbs_step_t        nxt;

        always_comb nxt = prbs_advance(lfsr_q);

        assign gen_bus[g*BYTE_W +: BYTE_W] = (pat == PAT_FIXED) ? FIX_BYTE : nxt.data;

        always_ff @(posedge clk) begin
            if (rst || !gen_on) begin
                lfsr_q <= lane_seed(g);
            end else if (pat == PAT_PRBS) begin
                lfsr_q <= nxt.state;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_a <= '0;
            tx_b <= '0;
        end else begin
            tx_a <= (gen_on && !dir) ? gen_bus : norm_a;
            tx_b <= (gen_on &&  dir) ? gen_bus : norm_b;
        end
    end

    // R1
    gen_idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !(en_reg || en_pin) |=> (tx_a == $past(norm_a)) && (tx_b == $past(norm_b)));

    // R2
    gen_other_path_chk: assert property (@(posedge clk) disable iff (rst)
        ((en_reg || en_pin) && !dir) |=> (tx_b == $past(norm_b)));

    // R2
    gen_other_path_b_chk: assert property (@(posedge clk) disable iff (rst)
        ((en_reg || en_pin) && dir) |=> (tx_a == $past(norm_a)));

endmodule

// File: rtl/bist_lane_chk.sv
module bist_lane_chk
    import bist_pkg::*;
#(
    parameter int                CNT_W    = 16,
    parameter logic [BYTE_W-1:0] FIX_BYTE = 8'h96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  pat_e              pat,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              aligned,
    input  logic              clr_cnt,
    input  logic              clr_flag,
    output logic              err_flag,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam int SEED_BYTES = (PRBS_W + BYTE_W - 1) / BYTE_W;
    localparam int SEED_W     = $clog2(SEED_BYTES + 1);

    ck_state_e         st_q;
    logic [PRBS_W-1:0] ref_q;
    logic [SEED_W-1:0] seed_n_q;

    prbs_step_t        step_w;
    logic [BYTE_W-1:0] expect_b;
    logic              check_now;
    logic [POP_W-1:0]  miss_n;
    logic [CNT_W-1:0]  cnt_base;
    logic [CNT_W:0]    cnt_sum;
    logic [CNT_W-1:0]  cnt_d;
    logic [PRBS_W-1:0] ref_shift;

    always_comb begin
        step_w    = prbs_advance(ref_q);
        expect_b  = (pat == PAT_FIXED) ? FIX_BYTE : step_w.data;
        check_now = en && ((st_q == CK_RUN) ||
                           (st_q == CK_IDLE && aligned && pat == PAT_FIXED));
        miss_n    = check_now ? ones_in_byte(rx_byte ^ expect_b) : '0;
        cnt_base  = clr_cnt ? '0 : err_cnt;
        cnt_sum   = {1'b0, cnt_base} + (CNT_W + 1)'(miss_n);
        cnt_d     = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
        ref_shift = {ref_q[PRBS_W-BYTE_W-1:0], rx_byte};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= CK_IDLE;
            ref_q    <= '0;
            seed_n_q <= '0;
            err_flag <= 1'b0;
            err_cnt  <= '0;
        end else begin
            err_cnt <= cnt_d;
            if (!en) begin
                st_q     <= CK_IDLE;
                ref_q    <= '0;
                seed_n_q <= '0;
                err_flag <= 1'b0;
            end else begin
                err_flag <= (err_flag && !clr_flag) || (miss_n != '0);
                case (st_q)
                    CK_IDLE: begin
                        if (aligned) begin
                            if (pat == PAT_FIXED) begin
                                st_q <= CK_RUN;
                            end else begin
                                st_q     <= CK_SEED;
                                ref_q    <= ref_shift;
                                seed_n_q <= SEED_W'(1);
                            end
                        end
                    end
                    CK_SEED: begin
                        ref_q    <= ref_shift;
                        seed_n_q <= seed_n_q + 1'b1;
                        if (seed_n_q == SEED_W'(SEED_BYTES - 1)) begin
                            st_q <= CK_RUN;
                        end
                    end
                    CK_RUN: begin
                        if (pat == PAT_PRBS) begin
                            ref_q <= step_w.state;
                        end
                    end
                    default: st_q <= CK_IDLE;
                endcase
            end
        end
    end

    // R5
    no_count_unaligned_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CK_IDLE && !aligned && !clr_cnt) |=> $stable(err_cnt));

    // R6
    seed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CK_SEED && !clr_cnt) |=> $stable(err_cnt));

    // R8
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_cnt |=> (err_cnt >= $past(err_cnt)));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && en && !clr_flag) |=> err_flag);

    // R9
    cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_cnt == '1 && !clr_cnt) |=> (err_cnt == '1));

    // R11
    flag_clear_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !err_flag);

endmodule

// File: rtl/bist_engine.sv
module bist_engine
    import bist_pkg::*;
#(
    parameter int                LANES    = 4,
    parameter int                CNT_W    = 16,
    parameter logic [BYTE_W-1:0] FIX_BYTE = 8'h96
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      gen_en_reg,
    input  logic                                      gen_en_pin,
    input  logic                                      gen_dir,
    input  logic                                      gen_pat,
    input  logic [LANES*BYTE_W-1:0]                   norm_tx_a,
    input  logic [LANES*BYTE_W-1:0]                   norm_tx_b,
    output logic [LANES*BYTE_W-1:0]                   tx_a,
    output logic [LANES*BYTE_W-1:0]                   tx_b,
    input  logic                                      chk_en,
    input  logic                                      chk_src,
    input  logic                                      chk_pat,
    input  logic [LANES*BYTE_W-1:0]                   rx_a,
    input  logic [LANES*BYTE_W-1:0]                   rx_b,
    input  logic [LANES-1:0]                          rx_a_aligned,
    input  logic [LANES-1:0]                          rx_b_aligned,
    output logic [LANES-1:0]                          err_flag,
    input  logic                                      rd_en,
    input  logic                                      rd_sel,
    input  logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] rd_lane,
    output logic [CNT_W-1:0]                          rd_data
);
    localparam int BUS_W      = LANES * BYTE_W;
    localparam int LANE_IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [BUS_W-1:0] rx_pick;
    logic [LANES-1:0] al_pick;
    logic [LANES-1:0] lane_flag;
    logic [CNT_W-1:0] lane_cnt [LANES];
    logic             flag_rd;

    assign rx_pick  = chk_src ? rx_b : rx_a;
    assign al_pick  = chk_src ? rx_b_aligned : rx_a_aligned;
    assign flag_rd  = rd_en && !rd_sel;
    assign err_flag = lane_flag;

    bist_gen #(
        .LANES    (LANES),
        .FIX_BYTE (FIX_BYTE)
    ) u_gen (
        .clk    (clk),
        .rst    (rst),
        .en_reg (gen_en_reg),
        .en_pin (gen_en_pin),
        .dir    (gen_dir),
        .pat    (pat_e'(gen_pat)),
        .norm_a (norm_tx_a),
        .norm_b (norm_tx_b),
        .tx_a   (tx_a),
        .tx_b   (tx_b)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        logic cnt_rd;
        assign cnt_rd = rd_en && rd_sel && (rd_lane == LANE_IDX_W'(g));

        bist_lane_chk #(
            .CNT_W    (CNT_W),
            .FIX_BYTE (FIX_BYTE)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .en       (chk_en),
            .pat      (pat_e'(chk_pat)),
            .rx_byte  (rx_pick[g*BYTE_W +: BYTE_W]),
            .aligned  (al_pick[g]),
            .clr_cnt  (cnt_rd),
            .clr_flag (flag_rd),
            .err_flag (lane_flag[g]),
            .err_cnt  (lane_cnt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_sel ? lane_cnt[rd_lane] : CNT_W'(lane_flag);
        end
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/bist_engine_bench.sv
module bist_engine_bench;
    localparam int         LANES = 4;
    localparam logic [7:0] FIX   = 8'h96;

    logic        clk = 1'b0;
    logic        rst;
    logic        gen_en_reg, gen_en_pin, gen_dir, gen_pat;
    logic [31:0] norm_tx_a, norm_tx_b, tx_a, tx_b;
    logic        chk_en, chk_src, chk_pat;
    logic [31:0] rx_a, rx_b;
    logic [3:0]  rx_a_aligned, rx_b_aligned, err_flag;
    logic        rd_en, rd_sel;
    logic [1:0]  rd_lane;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    bist_engine u_bist_engine (
        .clk(clk), .rst(rst),
        .gen_en_reg(gen_en_reg), .gen_en_pin(gen_en_pin), .gen_dir(gen_dir), .gen_pat(gen_pat),
        .norm_tx_a(norm_tx_a), .norm_tx_b(norm_tx_b), .tx_a(tx_a), .tx_b(tx_b),
        .chk_en(chk_en), .chk_src(chk_src), .chk_pat(chk_pat),
        .rx_a(rx_a), .rx_b(rx_b), .rx_a_aligned(rx_a_aligned), .rx_b_aligned(rx_b_aligned),
        .err_flag(err_flag), .rd_en(rd_en), .rd_sel(rd_sel), .rd_lane(rd_lane), .rd_data(rd_data)
    );

    int n_checks = 0;
    int n_errs   = 0;

    // stimulus modes: 0 random, 1 loop from tx, 2 bench PRBS stream, 3 constant
    int          ra_mode = 0, rb_mode = 0;
    logic [31:0] rx_const_a = '0, inj_a = '0, inj_b = '0;
    logic [22:0] bs [LANES];

    // reference model state
    logic [22:0] m_gen [LANES];
    logic [22:0] m_ref [LANES];
    int          m_st [LANES];
    int          m_seedn [LANES];
    bit          m_flag [LANES];
    int          m_cnt [LANES];
    logic [31:0] m_tx_a, m_tx_b;
    logic [15:0] m_rd;
    bit          rd_due;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lfsr_byte(inout logic [22:0] s);
        logic [7:0] b = '0;
        for (int k = 0; k < 8; k++) begin
            logic fb = s[22] ^ s[17];
            s = {s[21:0], fb};
            b = {b[6:0], fb};
        end
        return b;
    endfunction

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(v[k]);
        return n;
    endfunction

    function automatic logic [3:0] m_flags();
        logic [3:0] f;
        for (int l = 0; l < LANES; l++) f[l] = m_flag[l];
        return f;
    endfunction

    task automatic model_edge();
        logic [31:0] gw;
        bit on;
        if (rst) begin
            for (int l = 0; l < LANES; l++) begin
                m_gen[l] = 23'h7FFFFF - 23'(l);
                m_ref[l] = '0; m_st[l] = 0; m_seedn[l] = 0; m_flag[l] = 0; m_cnt[l] = 0;
            end
            m_tx_a = '0; m_tx_b = '0; m_rd = '0; rd_due = 0;
            return;
        end
        rd_due = rd_en;
        if (rd_en) m_rd = rd_sel ? 16'(m_cnt[rd_lane]) : {12'b0, m_flags()};
        for (int l = 0; l < LANES; l++) begin
            logic [7:0] rx = chk_src ? rx_b[8*l +: 8] : rx_a[8*l +: 8];
            bit al = chk_src ? rx_b_aligned[l] : rx_a_aligned[l];
            int e = 0;
            int base;
            if (chk_en) begin
                if (m_st[l] == 0) begin
                    if (al) begin
                        if (chk_pat) begin e = ones(rx ^ FIX); m_st[l] = 2; end
                        else begin m_ref[l] = {m_ref[l][14:0], rx}; m_seedn[l] = 1; m_st[l] = 1; end
                    end
                end else if (m_st[l] == 1) begin
                    m_ref[l] = {m_ref[l][14:0], rx};
                    m_seedn[l]++;
                    if (m_seedn[l] == 3) m_st[l] = 2;
                end else begin
                    if (chk_pat) e = ones(rx ^ FIX);
                    else e = ones(rx ^ lfsr_byte(m_ref[l]));
                end
            end
            base = (rd_en && rd_sel && rd_lane == 2'(l)) ? 0 : m_cnt[l];
            m_cnt[l] = (base + e > 65535) ? 65535 : base + e;
            if (!chk_en) begin
                m_flag[l] = 0; m_st[l] = 0; m_ref[l] = '0; m_seedn[l] = 0;
            end else begin
                m_flag[l] = (m_flag[l] && !(rd_en && !rd_sel)) || (e != 0);
            end
        end
        on = gen_en_reg || gen_en_pin;
        for (int l = 0; l < LANES; l++) begin
            if (!on) begin
                m_gen[l] = 23'h7FFFFF - 23'(l);
                gw[8*l +: 8] = '0;
            end else if (gen_pat) gw[8*l +: 8] = FIX;
            else gw[8*l +: 8] = lfsr_byte(m_gen[l]);
        end
        m_tx_a = (on && !gen_dir) ? gw : norm_tx_a;
        m_tx_b = (on &&  gen_dir) ? gw : norm_tx_b;
    endtask

    task automatic compare();
        chk(tx_a === m_tx_a, "R1/R2/R3 tx_a", tx_a, m_tx_a);
        chk(tx_b === m_tx_b, "R1/R2/R3 tx_b", tx_b, m_tx_b);
        chk(err_flag === m_flags(), "R8 err_flag", {28'b0, err_flag}, {28'b0, m_flags()});
        if (rd_due) chk(rd_data === m_rd, "R10 rd_data", {16'b0, rd_data}, {16'b0, m_rd});
    endtask

    task automatic step();
        case (ra_mode)
            0: rx_a = $urandom;
            1: rx_a = tx_a;
            default: rx_a = rx_const_a;
        endcase
        rx_a = rx_a ^ inj_a; inj_a = '0;
        case (rb_mode)
            0: rx_b = $urandom;
            1: rx_b = tx_b;
            2: for (int l = 0; l < LANES; l++) rx_b[8*l +: 8] = lfsr_byte(bs[l]);
            default: rx_b = '0;
        endcase
        rx_b = rx_b ^ inj_b; inj_b = '0;
        if (!rst) begin norm_tx_a = $urandom; norm_tx_b = $urandom; end
        @(posedge clk);
        #1;
        model_edge();
        compare();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_read(input bit sel, input int lane, output logic [15:0] v);
        rd_en = 1'b1; rd_sel = sel; rd_lane = 2'(lane);
        step();
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst = 1'b1;
        gen_en_reg = 0; gen_en_pin = 0; gen_dir = 0; gen_pat = 0;
        norm_tx_a = '0; norm_tx_b = '0; rx_a = '0; rx_b = '0;
        chk_en = 0; chk_src = 0; chk_pat = 0;
        rx_a_aligned = '0; rx_b_aligned = '0;
        rd_en = 0; rd_sel = 0; rd_lane = '0;
        steps(3);
        chk(tx_a == '0 && tx_b == '0, "R1 reset tx", tx_a, 32'h0);
        chk(err_flag == '0, "R8 reset flags", {28'b0, err_flag}, 32'h0);
        chk(rd_data == '0, "R10 reset rd_data", {16'b0, rd_data}, 32'h0);
        rst = 1'b0;

        // R1: generator off, traffic passes
        steps(8);

        // R3/R6: PRBS on path A looped back into the checker
        gen_en_reg = 1; gen_dir = 0; gen_pat = 0;
        ra_mode = 1; chk_en = 1; chk_src = 0; chk_pat = 0;
        steps(5);
        rx_a_aligned = 4'hF;
        steps(30);
        for (int l = 0; l < LANES; l++) begin
            do_read(1, l, v);
            chk(v == 16'h0, "R6 prbs clean loop count", {16'b0, v}, 32'h0);
        end
        inj_a = 32'h0005_0000;
        step();
        chk(err_flag == 4'b0100, "R8 flag after error", {28'b0, err_flag}, 32'h4);
        do_read(1, 2, v);
        chk(v == 16'd2, "R8 bit count", {16'b0, v}, 32'd2);
        do_read(1, 2, v);
        chk(v == 16'd0, "R10 counter cleared", {16'b0, v}, 32'd0);
        do_read(0, 0, v);
        chk(v == 16'h0004, "R10 flag word", {16'b0, v}, 32'h4);
        chk(err_flag == 4'b0, "R10 flag cleared", {28'b0, err_flag}, 32'h0);

        // R5/R7: constant byte on path B via the pin
        gen_en_reg = 0; gen_en_pin = 1; gen_dir = 1; gen_pat = 1;
        chk_en = 0; step();
        chk_src = 1; chk_pat = 1; chk_en = 1; rb_mode = 0; rx_b_aligned = '0;
        steps(10);
        for (int l = 0; l < LANES; l++) begin
            do_read(1, l, v);
            chk(v == 16'h0, "R5 no count before alignment", {16'b0, v}, 32'h0);
        end
        rb_mode = 1; steps(2);
        rx_b_aligned = 4'b0001; steps(5);
        rx_b_aligned = 4'b1111; inj_b = 32'h0000_0300;
        step();
        steps(4);
        do_read(1, 1, v);
        chk(v == 16'd2, "R7 aligned byte checked", {16'b0, v}, 32'd2);
        inj_b = 32'hFF00_0000; step();
        do_read(1, 3, v);
        chk(v == 16'd8, "R7 constant mismatch count", {16'b0, v}, 32'd8);

        // R11: disabling clears flags, counters kept
        inj_b = 32'h0000_0100; step();
        chk(err_flag[1] == 1'b1, "R11 flag set before disable", {31'b0, err_flag[1]}, 32'h1);
        chk_en = 0; step();
        chk(err_flag == 4'b0, "R11 flags cleared", {28'b0, err_flag}, 32'h0);
        chk_en = 1; step();
        do_read(1, 1, v);
        chk(v == 16'd1, "R11 counter retained", {16'b0, v}, 32'd1);

        // R4: generator constant on A, checker PRBS on B from a foreign stream
        gen_en_pin = 0; gen_en_reg = 1; gen_dir = 0; gen_pat = 1;
        chk_en = 0; step();
        for (int l = 0; l < LANES; l++) bs[l] = 23'h2F00D1 + 23'(l * 1013);
        rb_mode = 2; chk_pat = 0; chk_src = 1; rx_b_aligned = 4'hF; chk_en = 1;
        steps(40);
        for (int l = 0; l < LANES; l++) begin
            do_read(1, l, v);
            chk(v == 16'h0, "R4 independent pattern count", {16'b0, v}, 32'h0);
        end
        inj_b = 32'h0000_0080; step();
        do_read(1, 0, v);
        chk(v == 16'd1, "R6 error after self-seed", {16'b0, v}, 32'd1);

        // R9: saturation
        gen_en_reg = 0;
        chk_en = 0; step();
        chk_src = 0; chk_pat = 1; ra_mode = 3; rx_const_a = ~{4{FIX}};
        rx_a_aligned = 4'hF; chk_en = 1;
        steps(8200);
        do_read(1, 0, v);
        chk(v == 16'hFFFF, "R9 saturated counter", {16'b0, v}, 32'hFFFF);

        summary();
        $finish;
    end
endmodule